// File: doc/BRIEF.md
# Virtual JTAG Hub with Node Enumeration

This block lets one physical TAP controller serve several virtual debug nodes. The TAP decodes two user instructions and passes the block a select for each. The block also receives the DR-path strobes for capture, shift and update, together with TDI, and it drives TDO. The first select is the virtual-IR select, used while the device IR holds 0x0E. Under it the block shifts a combined register. The upper bits of that register hold a node address and the lower bits hold a virtual instruction. On update-DR the block latches both into `act_addr` and `act_vir`. Address 0 always names the hub itself.

The second select is the virtual-DR select, used while the device IR holds 0x0C. When address 0 and virtual instruction 0 (hub-info) are latched, it reads out identification data as 4-bit scans. Each scan is closed by its own update-DR, and that update advances a nibble pointer. The hub configuration word comes out first, least significant nibble first. Next comes one info word for each node, in address order starting at address 1. The node data registers are stubbed as one-bit bypass stages, and the hub routes virtual-DR scans to the one addressed.

A small scan controller drives the datapath. Its states are S_IDLE, S_VIR_SCAN, S_INFO_SCAN, S_NODE_SCAN and S_NULL_SCAN. Capture-DR with the virtual-IR select moves any state to S_VIR_SCAN. Capture-DR with the virtual-DR select moves any state to S_INFO_SCAN when hub-info is latched. It moves to S_NODE_SCAN when a valid node address is latched, and to S_NULL_SCAN otherwise. Update-DR moves any scan state back to S_IDLE, and so does test-logic-reset.

Top module: `vjtag_hub`

## Requirements
- R1: Under the virtual-IR select, the DR is N_W+M_W bits long, with N_W = ceil(log2(NODE_CNT+1)). It shifts LSB first from TDI toward TDO, and capture loads the currently latched {address, virtual IR}. On update, the upper N_W bits go to `act_addr` and the lower M_W bits go to `act_vir`.
- R2: A 64-bit all-zero virtual-IR scan leaves `act_addr` = 0 and `act_vir` = 0 (hub-info), whatever the earlier selection.
- R3: With hub-info latched, the first eight 4-bit virtual-DR scans return the 32-bit configuration word, least significant nibble first. Within each scan the nibble's bit 0 leaves first.
- R4: The nibble pointer moves only on update-DR of a hub-info scan. A capture and shift with no update returns the same nibble again on the next scan.
- R5: The configuration word holds the version in bits 31:27, the node count in bits 26:19, manufacturer 0x06E in bits 18:8, and M_W in bits 7:0.
- R6: After the configuration word, each group of 8 further nibble scans returns one node's 32-bit info word. The nodes follow address order from 1 to NODE_CNT.
- R7: Once the last node's word has been read, every further nibble scan returns 0.
- R8: Test-logic-reset, or `trst_n` low, clears `act_addr`, `act_vir` and the nibble pointer to 0.
- R9: Every virtual-IR update resets the nibble pointer, so enumeration restarts at nibble 0 of the configuration word.
- R10: With a node address from 1 to NODE_CNT latched, virtual-DR scans pass through that node's one-bit bypass stage. Capture loads 0, and TDO lags TDI by one shift.
- R11: TDO is 0 in S_IDLE and throughout a virtual-DR scan in S_NULL_SCAN, which is entered when hub address 0 is latched with a nonzero virtual IR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous reset, active low |
| tlr | input | 1 | TAP is in test-logic-reset |
| capture_dr | input | 1 | TAP is in capture-DR |
| shift_dr | input | 1 | TAP is in shift-DR |
| update_dr | input | 1 | TAP is in update-DR |
| sel_vir | input | 1 | Device IR holds the virtual-IR instruction (0x0E) |
| sel_vdr | input | 1 | Device IR holds the virtual-DR instruction (0x0C) |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out |
| act_addr | output | N_W (2) | Latched node address, 0 = hub |
| act_vir | output | M_W (4) | Latched virtual instruction |

## Verification
On every cycle, the assertions check four things. The latched address and virtual IR must equal the shifted register after a virtual-IR update. The nibble pointer holds still without update-DR and never passes its end value. Test-logic-reset clears everything, and TDO stays quiet in idle. They also check that a bypass stage copies TDI on each shift. Only the bench scenarios can show the enumeration order itself. That covers the field layout of the configuration word, the node words in address order, the zero tail and the restart after a new selection. Those scenarios also show the 64-bit zero scan, a nibble repeated when update is missed, and the one-bit lag through an addressed node.

// File: rtl/vjh_pkg.sv
package vjh_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_VIR_SCAN,
        S_INFO_SCAN,
        S_NODE_SCAN,
        S_NULL_SCAN
    } scan_state_t;

    localparam logic [10:0] HUB_MFG = 11'h06E;

    function automatic logic [31:0] hub_cfg_word(input logic [4:0] ver,
                                                 input logic [7:0] cnt,
                                                 input logic [7:0] mw);
        return {ver, cnt, HUB_MFG, mw};
    endfunction

endpackage

// File: rtl/vjh_scan_ctrl.sv
module vjh_scan_ctrl
    import vjh_pkg::*;
(
    input  logic        tck,
    input  logic        trst_n,
    input  logic        tlr,
    input  logic        capture_dr,
    input  logic        shift_dr,
    input  logic        update_dr,
    input  logic        sel_vir,
    input  logic        sel_vdr,
    input  logic        hub_info,
    input  logic        node_ok,
    output scan_state_t state,
    output logic        vir_cap,
    output logic        vir_shift,
    output logic        vir_upd,
    output logic        info_cap,
    output logic        info_shift,
    output logic        info_upd,
    output logic        node_cap,
    output logic        node_shift
);

    scan_state_t nxt;

    always_comb begin
        nxt = state;
        if (capture_dr && sel_vir)
            nxt = S_VIR_SCAN;
        else if (capture_dr && sel_vdr)
            nxt = hub_info ? S_INFO_SCAN : (node_ok ? S_NODE_SCAN : S_NULL_SCAN);
        else if (update_dr)
            nxt = S_IDLE;
    end

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n)
            state <= S_IDLE;
        else if (tlr)
            state <= S_IDLE;
        else
            state <= nxt;
    end

    always_comb begin
        vir_cap    = capture_dr && sel_vir;
        info_cap   = capture_dr && !sel_vir && sel_vdr && hub_info;
        node_cap   = capture_dr && !sel_vir && sel_vdr && !hub_info && node_ok;
        vir_shift  = 1'b0;
        vir_upd    = 1'b0;
        info_shift = 1'b0;
        info_upd   = 1'b0;
        node_shift = 1'b0;
        unique case (state)
            S_IDLE: ;
            S_VIR_SCAN: begin
                vir_shift = shift_dr && !capture_dr;
                vir_upd   = update_dr && !capture_dr;
            end
            S_INFO_SCAN: begin
                info_shift = shift_dr && !capture_dr;
                info_upd   = update_dr && !capture_dr;
            end
            S_NODE_SCAN: node_shift = shift_dr && !capture_dr;
            S_NULL_SCAN: ;
            default: ;
        endcase
    end

    // R4: an update with no capture closes the scan
    p_scan_close_r4: assert property (@(posedge tck) disable iff (!trst_n)
        (update_dr && !capture_dr) |=> state == S_IDLE);

    // R8: test-logic-reset returns the controller to idle
    p_tlr_idle_r8: assert property (@(posedge tck) disable iff (!trst_n)
        tlr |=> state == S_IDLE);

endmodule

// File: rtl/vjh_info_rom.sv
module vjh_info_rom
    import vjh_pkg::*;
#(
    parameter int               NODE_CNT  = 3,
    parameter int               M_W       = 4,
    parameter logic [4:0]       HUB_VER   = 5'd1,
    parameter logic [NODE_CNT*32-1:0] NODE_INFO = '0,
    parameter int               PTR_W     = 6
) (
    input  logic [PTR_W-1:0] ptr,
    output logic [3:0]       nib
);

    localparam int TOT = (NODE_CNT + 1) * 8;

    logic [31:0] words [NODE_CNT+1];

    assign words[0] = hub_cfg_word(HUB_VER, 8'(NODE_CNT), 8'(M_W));

    for (genvar g = 0; g < NODE_CNT; g++) begin : g_word
        assign words[g+1] = NODE_INFO[32*g +: 32];
    end

    logic [PTR_W-4:0] widx;
    logic [2:0]       sel;

    assign widx = ptr[PTR_W-1:3];
    assign sel  = ptr[2:0];

    always_comb begin
        nib = 4'h0;
        if (int'(ptr) < TOT) begin
            for (int k = 0; k <= NODE_CNT; k++) begin
                if (int'(widx) == k)
                    nib = words[k][4*sel +: 4];
            end
        end
    end

endmodule

// File: rtl/vjh_node_bypass.sv
module vjh_node_bypass (
    input  logic tck,
    input  logic trst_n,
    input  logic tlr,
    input  logic cap,
    input  logic shift,
    input  logic tdi,
    output logic q
);

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n)
            q <= 1'b0;
        else if (tlr || cap)
            q <= 1'b0;
        else if (shift)
            q <= tdi;
    end

    // R10: each shift copies TDI into the stage
    p_bypass_copy_r10: assert property (@(posedge tck) disable iff (!trst_n)
        (shift && !tlr && !cap) |=> q == $past(tdi));

endmodule

// File: rtl/vjtag_hub.sv
module vjtag_hub
    import vjh_pkg::*;
#(
    parameter int                     NODE_CNT  = 3,
    parameter int                     M_W       = 4,
    parameter logic [4:0]             HUB_VER   = 5'd1,
    parameter logic [NODE_CNT*32-1:0] NODE_INFO = {
        {5'd1, 8'h00, 11'h06E, 8'd1},
        {5'd1, 8'h08, 11'h06E, 8'd0},
        {5'd2, 8'h84, 11'h06E, 8'd0}},
    localparam int N_W = $clog2(NODE_CNT + 1)
) (
    input  logic           tck,
    input  logic           trst_n,
    input  logic           tlr,
    input  logic           capture_dr,
    input  logic           shift_dr,
    input  logic           update_dr,
    input  logic           sel_vir,
    input  logic           sel_vdr,
    input  logic           tdi,
    output logic           tdo,
    output logic [N_W-1:0] act_addr,
    output logic [M_W-1:0] act_vir
);

    localparam int VR_W  = N_W + M_W;
    localparam int TOT   = (NODE_CNT + 1) * 8;
    localparam int PTR_W = $clog2(TOT + 1);

    scan_state_t      state;
    logic             vir_cap, vir_shift, vir_upd;
    logic             info_cap, info_shift, info_upd;
    logic             node_cap, node_shift;
    logic             hub_info, node_ok;
    logic [VR_W-1:0]  vir_sr;
    logic [3:0]       info_sr;
    logic [3:0]       rom_nib;
    logic [PTR_W-1:0] ptr;
    logic [NODE_CNT-1:0] byp_q;
    logic             node_tdo;

    assign hub_info = (act_addr == '0) && (act_vir == '0);
    assign node_ok  = (act_addr != '0) && (int'(act_addr) <= NODE_CNT);

    vjh_scan_ctrl u_ctrl (
        .tck        (tck),
        .trst_n     (trst_n),
        .tlr        (tlr),
        .capture_dr (capture_dr),
        .shift_dr   (shift_dr),
        .update_dr  (update_dr),
        .sel_vir    (sel_vir),
        .sel_vdr    (sel_vdr),
        .hub_info   (hub_info),
        .node_ok    (node_ok),
        .state      (state),
        .vir_cap    (vir_cap),
        .vir_shift  (vir_shift),
        .vir_upd    (vir_upd),
        .info_cap   (info_cap),
        .info_shift (info_shift),
        .info_upd   (info_upd),
        .node_cap   (node_cap),
        .node_shift (node_shift)
    );

    // Virtual IR shift register and latched selection
    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) begin
            vir_sr   <= '0;
            act_addr <= '0;
            act_vir  <= '0;
        end else if (tlr) begin
            vir_sr   <= '0;
            act_addr <= '0;
            act_vir  <= '0;
        end else begin
            if (vir_cap)
                vir_sr <= {act_addr, act_vir};
            else if (vir_shift)
                vir_sr <= {tdi, vir_sr[VR_W-1:1]};
            if (vir_upd) begin
                act_addr <= vir_sr[VR_W-1:M_W];
                act_vir  <= vir_sr[M_W-1:0];
            end
        end
    end

    // Nibble pointer: restart on selection, step on info update, saturate
    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n)
            ptr <= '0;
        else if (tlr || vir_upd)
            ptr <= '0;
        else if (info_upd && int'(ptr) < TOT)
            ptr <= ptr + 1'b1;
    end

    vjh_info_rom #(
        .NODE_CNT  (NODE_CNT),
        .M_W       (M_W),
        .HUB_VER   (HUB_VER),
        .NODE_INFO (NODE_INFO),
        .PTR_W     (PTR_W)
    ) u_rom (
        .ptr (ptr),
        .nib (rom_nib)
    );

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n)
            info_sr <= '0;
        else if (tlr)
            info_sr <= '0;
        else if (info_cap)
            info_sr <= rom_nib;
        else if (info_shift)
            info_sr <= {tdi, info_sr[3:1]};
    end

    // Node data register stubs
    for (genvar g = 0; g < NODE_CNT; g++) begin : g_node
        logic here;
        assign here = (int'(act_addr) == g + 1);
        vjh_node_bypass u_byp (
            .tck    (tck),
            .trst_n (trst_n),
            .tlr    (tlr),
            .cap    (node_cap && here),
            .shift  (node_shift && here),
            .tdi    (tdi),
            .q      (byp_q[g])
        );
    end

    always_comb begin
        node_tdo = 1'b0;
        for (int k = 0; k < NODE_CNT; k++) begin
            if (int'(act_addr) == k + 1)
                node_tdo = byp_q[k];
        end
    end

    always_comb begin
        tdo = 1'b0;
        unique case (state)
            S_IDLE:      tdo = 1'b0;
            S_VIR_SCAN:  tdo = vir_sr[0];
            S_INFO_SCAN: tdo = info_sr[0];
            S_NODE_SCAN: tdo = node_tdo;
            S_NULL_SCAN: tdo = 1'b0;
            default:     tdo = 1'b0;
        endcase
    end

    // R1: update of a virtual-IR scan latches the shifted value
    p_vir_latch_r1: assert property (@(posedge tck) disable iff (!trst_n)
        (state == S_VIR_SCAN && update_dr && !capture_dr && !tlr)
            |=> {act_addr, act_vir} == $past(vir_sr));

    // R4: the pointer holds unless an update-DR or reset happens
    p_ptr_hold_r4: assert property (@(posedge tck) disable iff (!trst_n)
        (!update_dr && !tlr) |=> $stable(ptr));

    // R7: the pointer never runs past the end of the last node word
    p_ptr_bound_r7: assert property (@(posedge tck) disable iff (!trst_n)
        int'(ptr) <= TOT);

    // R8: test-logic-reset clears the selection and the pointer
    p_tlr_clear_r8: assert property (@(posedge tck) disable iff (!trst_n)
        tlr |=> (act_addr == '0 && act_vir == '0 && ptr == '0));

    // R11: TDO is quiet outside a scan and in a null scan
    p_tdo_quiet_r11: assert property (@(posedge tck) disable iff (!trst_n)
        (state == S_IDLE || state == S_NULL_SCAN) |-> !tdo);

endmodule

// File: tb/test_vjtag_hub.sv
module test_vjtag_hub;

    localparam int NODES = 3;
    localparam int MW    = 4;
    localparam int NW    = 2;
    localparam int VRW   = NW + MW;
    localparam logic [31:0] W1 = {5'd2, 8'h84, 11'h06E, 8'd0};
    localparam logic [31:0] W2 = {5'd1, 8'h08, 11'h06E, 8'd0};
    localparam logic [31:0] W3 = {5'd1, 8'h00, 11'h06E, 8'd1};
    localparam logic [4:0]  VER = 5'd3;

    logic tck = 1'b0;
    logic trst_n = 1'b0;
    logic tlr = 1'b0, capture_dr = 1'b0, shift_dr = 1'b0, update_dr = 1'b0;
    logic sel_vir = 1'b0, sel_vdr = 1'b0, tdi = 1'b0;
    logic tdo;
    logic [NW-1:0] act_addr;
    logic [MW-1:0] act_vir;

    int n_chk = 0;
    int n_fail = 0;
    int cycles = 0;

    always #4 tck = ~tck;

    vjtag_hub #(
        .NODE_CNT  (NODES),
        .M_W       (MW),
        .HUB_VER   (VER),
        .NODE_INFO ({W3, W2, W1})
    ) i_vjtag_hub (
        .tck (tck), .trst_n (trst_n), .tlr (tlr),
        .capture_dr (capture_dr), .shift_dr (shift_dr), .update_dr (update_dr),
        .sel_vir (sel_vir), .sel_vdr (sel_vdr), .tdi (tdi), .tdo (tdo),
        .act_addr (act_addr), .act_vir (act_vir)
    );

    function automatic logic [31:0] exp_word(input int i);
        case (i)
            0: return {VER, 8'(NODES), 11'h06E, 8'(MW)};
            1: return W1;
            2: return W2;
            3: return W3;
            default: return 32'h0;
        endcase
    endfunction

    function automatic logic [3:0] exp_nib(input int k);
        logic [31:0] w;
        w = exp_word(k / 8);
        return w[4*(k%8) +: 4];
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic scan(input logic vir, input logic [63:0] val, input int len,
                        input logic upd, output logic [63:0] got);
        got = '0;
        @(negedge tck);
        sel_vir = vir; sel_vdr = !vir; capture_dr = 1'b1;
        @(negedge tck);
        capture_dr = 1'b0;
        for (int i = 0; i < len; i++) begin
            got[i] = tdo;
            shift_dr = 1'b1; tdi = val[i];
            @(negedge tck);
        end
        shift_dr = 1'b0; tdi = 1'b0;
        if (upd) begin
            update_dr = 1'b1;
            @(negedge tck);
            update_dr = 1'b0;
        end
        sel_vir = 1'b0; sel_vdr = 1'b0;
    endtask

    task automatic select(input logic [NW-1:0] a, input logic [MW-1:0] v);
        logic [63:0] g;
        scan(1'b1, 64'({a, v}), VRW, 1'b1, g);
    endtask

    task automatic nibble(output logic [3:0] n);
        logic [63:0] g;
        scan(1'b0, 64'h0, 4, 1'b1, g);
        n = g[3:0];
    endtask

    task automatic pulse_tlr();
        @(negedge tck); tlr = 1'b1;
        @(negedge tck); tlr = 1'b0;
    endtask

    initial begin
        while (cycles < 150000) begin
            @(posedge tck);
            cycles++;
        end
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual %0d expected less", cycles);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [63:0] g;
        logic [3:0]  nb;
        logic [31:0] w;
        void'($urandom(32'h5eed));
        repeat (3) @(negedge tck);
        trst_n = 1'b1;
        @(negedge tck);

        // R8 / R11: reset state
        chk("R8 reset addr", 64'(act_addr), 0);
        chk("R8 reset vir", 64'(act_vir), 0);
        chk("R11 idle tdo", 64'(tdo), 0);

        // R1: latch and read back selection
        select(2'd2, 4'h5);
        chk("R1 addr latch", 64'(act_addr), 2);
        chk("R1 vir latch", 64'(act_vir), 5);
        scan(1'b1, 64'({2'd1, 4'hA}), VRW, 1'b1, g);
        chk("R1 capture readback", 64'(g[VRW-1:0]), 64'({2'd2, 4'h5}));
        chk("R1 second latch", 64'({act_addr, act_vir}), 64'({2'd1, 4'hA}));

        // R2: 64-bit zero scan selects hub-info
        scan(1'b1, 64'h0, 64, 1'b1, g);
        chk("R2 zero scan addr", 64'(act_addr), 0);
        chk("R2 zero scan vir", 64'(act_vir), 0);

        // R3 / R5: configuration word
        w = '0;
        for (int i = 0; i < 8; i++) begin
            nibble(nb);
            w[4*i +: 4] = nb;
        end
        chk("R3 config word", 64'(w), 64'(exp_word(0)));
        chk("R5 version field", 64'(w[31:27]), 64'(VER));
        chk("R5 count field", 64'(w[26:19]), NODES);
        chk("R5 mfg field", 64'(w[18:8]), 64'h06E);
        chk("R5 m field", 64'(w[7:0]), MW);

        // R6: node words in address order
        for (int n = 1; n <= NODES; n++) begin
            w = '0;
            for (int i = 0; i < 8; i++) begin
                nibble(nb);
                w[4*i +: 4] = nb;
            end
            chk("R6 node word", 64'(w), 64'(exp_word(n)));
            if (n == 2) chk("R6 debug node id", 64'(w[26:19]), 64'h08);
        end

        // R7: tail returns zero
        for (int i = 0; i < 4; i++) begin
            nibble(nb);
            chk("R7 tail nibble", 64'(nb), 0);
        end

        // R9: new selection restarts enumeration
        select(2'd0, 4'h0);
        nibble(nb);
        nibble(nb);
        nibble(nb);
        select(2'd0, 4'h0);
        nibble(nb);
        chk("R9 restart nibble", 64'(nb), 64'(exp_nib(0)));

        // R4: missing update repeats the nibble
        scan(1'b0, 64'h0, 4, 1'b0, g);
        chk("R4 no-update nibble", 64'(g[3:0]), 64'(exp_nib(1)));
        nibble(nb);
        chk("R4 repeated nibble", 64'(nb), 64'(exp_nib(1)));
        nibble(nb);
        chk("R4 next nibble", 64'(nb), 64'(exp_nib(2)));

        // R8: test-logic-reset clears selection and pointer
        select(2'd3, 4'h7);
        pulse_tlr();
        chk("R8 tlr addr", 64'(act_addr), 0);
        chk("R8 tlr vir", 64'(act_vir), 0);
        select(2'd0, 4'h0);
        nibble(nb);
        nibble(nb);
        pulse_tlr();
        nibble(nb);
        chk("R8 tlr pointer", 64'(nb), 64'(exp_nib(0)));

        // R10: bypass through node 2
        select(2'd2, 4'h8);
        g = 64'h0;
        begin
            logic [63:0] pat;
            pat = {32'h0, $urandom()};
            scan(1'b0, pat, 16, 1'b1, g);
            chk("R10 bypass lag", 64'(g[15:0]), 64'({pat[14:0], 1'b0}));
        end

        // R11: null scan with hub address and nonzero virtual IR
        select(2'd0, 4'h3);
        scan(1'b0, 64'hFFFF, 16, 1'b1, g);
        chk("R11 null scan", 64'(g[15:0]), 0);

        // Random mix
        for (int it = 0; it < 24; it++) begin
            logic [31:0] r;
            logic [NW-1:0] a;
            logic [MW-1:0] v;
            r = $urandom();
            a = r[1:0];
            v = r[5:2];
            if (it % 3 == 0) begin a = '0; v = '0; end
            select(a, v);
            chk("R1 random latch", 64'({act_addr, act_vir}), 64'({a, v}));
            if (a == 0 && v == 0) begin
                int k;
                k = $urandom_range(40, 1);
                for (int j = 0; j < k; j++) begin
                    nibble(nb);
                    if (j < 32)
                        chk("R6 random enumeration", 64'(nb), 64'(exp_nib(j)));
                    else
                        chk("R7 random tail", 64'(nb), 0);
                end
            end else if (a != 0) begin
                logic [63:0] pat;
                pat = {32'h0, $urandom()};
                scan(1'b0, pat, 12, 1'b1, g);
                chk("R10 random bypass", 64'(g[11:0]), 64'({pat[10:0], 1'b0}));
            end else begin
                scan(1'b0, 64'hFFF, 12, 1'b1, g);
                chk("R11 random null", 64'(g[11:0]), 0);
            end
        end

        @(negedge tck);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule